// File: doc/BRIEF.md
# Serial Magnitude Comparator, Least Significant Bit First

This block compares two unsigned words that arrive one bit pair per clock, starting with the least significant bit. A two-bit verdict register records whether the bits accepted so far make word a equal to, less than or greater than word b. Since the later bits carry more weight, any pair whose bits differ replaces the earlier verdict outright. Pairs whose bits match leave the verdict unchanged.

The caller starts a comparison by pulsing the synchronous clear. It then streams the bit pairs through a valid/ready handshake. A pair is consumed on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low only in cycles where `clr` is high, so a pair offered in such a cycle is not consumed and must be offered again. The block does not count bits. After presenting the last pair, the caller reads the outputs on the following cycle.

The verdict is encoded as follows:
- 00 means equal so far.
- 01 means a < b.
- 10 means a > b.

The three flags are taken straight from this code.

Top module: `serial_mag_cmp`

## Requirements
- R1: After the asynchronous active-low reset, `state_o` is 00 and `eq_o` is 1.
- R2: When `clr` is high at a rising edge, `state_o` becomes 00, even if `in_valid` is high in the same cycle. `in_ready` is 0 while `clr` is high and 1 otherwise.
- R3: A consumed pair with `a_bit == b_bit` leaves `state_o` unchanged.
- R4: A consumed pair with `a_bit=0`, `b_bit=1` sets `state_o` to 01 from any current code.
- R5: A consumed pair with `a_bit=1`, `b_bit=0` sets `state_o` to 10 from any current code.
- R6: On an edge where no pair is consumed and `clr` is low, `state_o` holds, whatever values `a_bit` and `b_bit` carry.
- R7: `eq_o` is 1 exactly when the code is 00. `lt_o` equals bit 0 of the code. `gt_o` equals bit 1 of the code.
- R8: Code 11 never appears on `state_o`. If that code is ever held, the next edge replaces it with 00.
- R9: Streaming a=1001 and b=0011 starting at bit 0 yields 00, 01, 01, 10 after the four pairs.
- R10: After a clear and all pairs of two unsigned words, `state_o` reports their unsigned ordering.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous start of a new comparison |
| in_valid | input | 1 | Bit pair offered |
| in_ready | output | 1 | Block can consume a pair (low during clear) |
| a_bit | input | 1 | Current bit of word a |
| b_bit | input | 1 | Current bit of word b |
| state_o | output | 2 | Verdict code: 00 equal, 01 a<b, 10 a>b |
| eq_o | output | 1 | Words equal so far |
| lt_o | output | 1 | a less than b so far |
| gt_o | output | 1 | a greater than b so far |

## Verification
The verdict register feeds the outputs directly. A wrong next-state decision therefore shows on `state_o` and on the flags one cycle after the pair that caused it.

A later differing pair can mask an earlier wrong verdict in the final result. For that reason the bench compares the code after every edge rather than only at the end of a word. Hold, clear priority and the override rule from each code are also driven on purpose, so a fault that leaves the final answer intact is still exposed at the cycle it happens.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    ST_EQ  = 2'b00,
    ST_LT  = 2'b01,
    ST_GT  = 2'b10,
    ST_BAD = 2'b11
  } cmp_state_e;
endpackage

// File: rtl/smc_next.sv
module smc_next
  import smc_pkg::*;
(
  input  cmp_state_e cur,
  input  logic       take,
  input  logic       a_bit,
  input  logic       b_bit,
  output cmp_state_e nxt
);
  always_comb begin
    nxt = cur;
    if (cur == ST_BAD) begin
      nxt = ST_EQ;
    end else if (take) begin
      unique case ({a_bit, b_bit})
        2'b01:   nxt = ST_LT;
        2'b10:   nxt = ST_GT;
        default: nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/smc_state_reg.sv
module smc_state_reg
  import smc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  cmp_state_e nxt,
  output cmp_state_e cur
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cur <= ST_EQ;
    else if (clr) cur <= ST_EQ;
    else          cur <= nxt;
  end
endmodule

// File: rtl/smc_decode.sv
module smc_decode
  import smc_pkg::*;
(
  input  cmp_state_e cur,
  output logic       eq_o,
  output logic       lt_o,
  output logic       gt_o
);
  logic [CODE_W-1:0] raw;
  assign raw  = cur;
  assign eq_o = ~|raw;
  assign lt_o = raw[0];
  assign gt_o = raw[1];
endmodule

// File: rtl/serial_mag_cmp.sv
module serial_mag_cmp
  import smc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       a_bit,
  input  logic       b_bit,
  output logic [1:0] state_o,
  output logic       eq_o,
  output logic       lt_o,
  output logic       gt_o
);
  cmp_state_e cur, nxt;
  logic       take;

  assign in_ready = ~clr;
  assign take     = in_valid & in_ready;

  smc_next u_next (
    .cur(cur), .take(take), .a_bit(a_bit), .b_bit(b_bit), .nxt(nxt)
  );

  smc_state_reg u_reg (
    .clk(clk), .rst_n(rst_n), .clr(clr), .nxt(nxt), .cur(cur)
  );

  smc_decode u_dec (
    .cur(cur), .eq_o(eq_o), .lt_o(lt_o), .gt_o(gt_o)
  );

  assign state_o = cur;
endmodule

// File: rtl/serial_mag_cmp_chk.sv
module serial_mag_cmp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       in_valid,
  input logic       in_ready,
  input logic       a_bit,
  input logic       b_bit,
  input logic [1:0] state_o,
  input logic       eq_o,
  input logic       lt_o,
  input logic       gt_o
);
  logic fire;
  assign fire = in_valid && in_ready;

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (state_o == 2'b00));

  p_same_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !clr && (a_bit == b_bit)) |=> $stable(state_o));

  p_lt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !clr && !a_bit && b_bit) |=> (state_o == 2'b01));

  p_gt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !clr && a_bit && !b_bit) |=> (state_o == 2'b10));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !clr) |=> $stable(state_o));

  p_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({eq_o, lt_o, gt_o}) == 1);

  p_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'b11);
endmodule

bind serial_mag_cmp serial_mag_cmp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
  .in_ready(in_ready), .a_bit(a_bit), .b_bit(b_bit), .state_o(state_o),
  .eq_o(eq_o), .lt_o(lt_o), .gt_o(gt_o)
);

// File: tb/sim_serial_mag_cmp.sv
module sim_serial_mag_cmp;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       in_valid = 1'b0;
  logic       a_bit = 1'b0;
  logic       b_bit = 1'b0;
  logic       in_ready;
  logic [1:0] state_o;
  logic       eq_o, lt_o, gt_o;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    logic [1:0] st;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  logic [1:0] model = 2'b00;

  serial_mag_cmp u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .in_ready(in_ready), .a_bit(a_bit), .b_bit(b_bit), .state_o(state_o),
    .eq_o(eq_o), .lt_o(lt_o), .gt_o(gt_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check2(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // R7 flag expectations derived from the code; R8 code 11 never seen
  task automatic check_all(input string tag, input logic [1:0] exp);
    check2(tag, state_o, exp);
    check2({tag, " R7 flags"}, {eq_o, lt_o, gt_o},
           {exp == 2'b00, exp[0], exp[1]});
    n_checks++;
    if (state_o === 2'b11) begin
      n_fail++;
      $display("FAIL R8: got %b expected not 11", state_o);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected code
  task automatic step(input logic c, input logic v, input logic a,
                      input logic b, input string tag);
    @(negedge clk);
    clr = c; in_valid = v; a_bit = a; b_bit = b;
    #1;
    check2("R2 in_ready", {1'b0, in_ready}, {1'b0, ~c});
    if (c)                   model = 2'b00;
    else if (v && !a && b)   model = 2'b01;
    else if (v && a && !b)   model = 2'b10;
    sb.push_back('{model, tag});
  endtask

  // Monitor: compares after every edge that has a queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check_all(e.tag, e.st);
      end
    end
  end

  task automatic run_words(input logic [WORD_W-1:0] wa, input logic [WORD_W-1:0] wb);
    logic [1:0] want;
    step(1'b1, 1'b0, 1'b0, 1'b0, "R2 clear");
    for (int i = 0; i < WORD_W; i++)
      step(1'b0, 1'b1, wa[i], wb[i], (i == WORD_W-1) ? "R10 final" : "R10 step");
    want = (wa < wb) ? 2'b01 : (wa > wb) ? 2'b10 : 2'b00;
    @(posedge clk); #2;
    check2("R10 ordering", state_o, want);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #2;
    check_all("R1 reset", 2'b00);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    check_all("R1 after release", 2'b00);

    // R9 worked example: a=1001, b=0011, LSB first
    step(1'b0, 1'b1, 1'b1, 1'b1, "R9 bit0");
    step(1'b0, 1'b1, 1'b0, 1'b1, "R9 bit1");
    step(1'b0, 1'b1, 1'b0, 1'b0, "R9 bit2");
    step(1'b0, 1'b1, 1'b1, 1'b0, "R9 bit3");

    // R6 no pair consumed: differing bits must not move the code (10)
    step(1'b0, 1'b0, 1'b0, 1'b1, "R6 idle 01");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R6 idle 10");

    // R4 from 10, R3 from 01, R5 from 01, R3 from 10
    step(1'b0, 1'b1, 1'b0, 1'b1, "R4 from 10");
    step(1'b0, 1'b1, 1'b1, 1'b1, "R3 hold 01 ones");
    step(1'b0, 1'b1, 1'b0, 1'b0, "R3 hold 01 zeros");
    step(1'b0, 1'b1, 1'b1, 1'b0, "R5 from 01");
    step(1'b0, 1'b1, 1'b0, 1'b0, "R3 hold 10");
    step(1'b0, 1'b1, 1'b1, 1'b0, "R5 from 10");
    step(1'b0, 1'b1, 1'b0, 1'b1, "R4 from 10 again");
    step(1'b0, 1'b1, 1'b0, 1'b1, "R4 from 01");

    // R2 clear with a valid a<b pair offered: clear wins
    step(1'b1, 1'b1, 1'b0, 1'b1, "R2 clear beats valid");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R6 idle after clear");
    step(1'b0, 1'b1, 1'b1, 1'b0, "R5 from 00");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R2 clear from 10");
    step(1'b0, 1'b1, 1'b0, 1'b1, "R4 from 00");

    // R10 words with fixed boundaries and random values
    run_words(8'h00, 8'h00);
    run_words(8'hFF, 8'hFF);
    run_words(8'h80, 8'h7F);
    run_words(8'h01, 8'h00);
    run_words(8'h7F, 8'h80);
    for (int k = 0; k < 24; k++)
      run_words(WORD_W'($urandom), WORD_W'($urandom));

    repeat (3) @(posedge clk);
    #2;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule